// File: doc/BRIEF.md
# Spread-Spectrum Delay-Code Sweeper

This block drives the control code of a delay line that widens or narrows the high phase of each cycle of a PLL clock. Moving that code slowly up and down spreads the clock's energy over a band of frequencies and lowers the peak of its emitted spectrum. The code is a signed number centred on zero. It walks in single steps from zero up to a programmable positive bound, then down to the matching negative bound, then back up, forming a symmetric triangle. A local interval timer sets how many clock cycles pass between two steps.

Modulation runs only when the enable input is set and the clock-source select picks the PLL clock. In every other case the code is parked at zero and a bypass flag tells the delay line to pass the clock through unchanged. The bound and interval inputs are captured only while the enable input is low, so a sweep never runs against bounds that changed partway through it.

Top module: `ssm_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `code_o` is 0 and `bypass_o` is 1.
- R2: Modulation is active only when `enable_i` is 1 and `clk_sel_i` equals 2 (the PLL source). Select codes 0, 1 and 3 give an idle block: from the next clock edge `code_o` is 0 and `bypass_o` is 1.
- R3: While active, each timer expiry moves `code_o` by exactly +1 or -1. The code starts upward from 0, turns downward on reaching +L and turns upward on reaching -L, where L is the captured bound. With L=1 and interval 0 the code runs 1, 0, -1, 0, 1 on successive edges.
- R4: `code_o` never leaves the range -L to +L, and a long enough sweep reaches both ends.
- R5: With captured interval N, timer expiries come every N+1 active edges. The first step lands on the (N+1)-th edge after activation, so `code_o` is still 0 after N edges and 1 after N+1.
- R6: A captured bound of 0 holds `code_o` at 0 while active, with `bypass_o` at 0.
- R7: `limit_i` and `interval_i` are captured on every edge at which `enable_i` is 0 and are held unchanged while `enable_i` is 1. Changing them during a sweep alters neither the reach of the code nor its step interval.
- R8: Leaving the active state returns `code_o` to 0 and clears the interval timer on the next edge. On re-entry the sweep restarts upward from 0, with the first step again N+1 edges later.
- R9: `bypass_o` is a registered flag: it is 0 on the cycle after an edge at which the block was active and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | PLL clock that the block runs on |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Modulation enable |
| clk_sel_i | input | SEL_W (2) | System clock source select; value PLL_SEL (2) picks the PLL |
| limit_i | input | LIM_W (5) | Sweep bound L, captured while disabled |
| interval_i | input | IVL_W (8) | Step interval N, captured while disabled; a step every N+1 cycles |
| code_o | output | LIM_W+1 (6) | Signed two's-complement delay-adjust code |
| bypass_o | output | 1 | 1 when the delay line must pass the clock unmodified |

## Verification
The checker watches on every edge that the code stays inside the captured bound, that it moves by exactly one unit at a timer expiry and holds still otherwise, that an idle block parks the code at zero with bypass raised, that the captured bound and interval cannot move while enabled, and that the timer count never passes the interval. Properties like these cannot show the shape of the sweep. The bench's scenarios have to show that the sweep starts upward, that it turns exactly at both bounds, that it lands on the first step after precisely N+1 edges, and that it restarts cleanly after a source switch. The bench also shows that bound and interval values written while enabled are taken up only after the next disable.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Sweep direction of the delay code.
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

  // Code after one step in the given direction.
  function automatic int step_code(int cur, dir_e dir);
    return (dir == DIR_UP) ? cur + 1 : cur - 1;
  endfunction

  // True when the stepped code sits on the bound it was heading for.
  function automatic bit hits_bound(int nxt, int lim, dir_e dir);
    return (dir == DIR_UP) ? (nxt >= lim) : (nxt <= -lim);
  endfunction

  // Direction after a turn.
  function automatic dir_e flip_dir(dir_e dir);
    return (dir == DIR_UP) ? DIR_DN : DIR_UP;
  endfunction

endpackage

// File: rtl/ssm_cfg_hold.sv
// Captures bound and interval while the block is disabled; freezes them
// while enabled so a running sweep keeps consistent bounds.
module ssm_cfg_hold #(
  parameter int LIM_W = 5,
  parameter int IVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             enable_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic [IVL_W-1:0] interval_i,
  output logic [LIM_W-1:0] lim_q_o,
  output logic [IVL_W-1:0] ivl_q_o
);

  logic load_w;
  assign load_w = ~enable_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lim_q_o <= '0;
      ivl_q_o <= '0;
    end else if (load_w) begin
      lim_q_o <= limit_i;
      ivl_q_o <= interval_i;
    end
  end

endmodule

// File: rtl/ssm_ivl_timer.sv
// Counts active cycles and fires one expiry every (interval+1) cycles.
module ssm_ivl_timer #(
  parameter int IVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             act_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             expire_o,
  output logic [IVL_W-1:0] cnt_o
);

  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] cnt_d;
  logic             at_end_w;

  assign at_end_w = (cnt_q == ivl_i);
  assign expire_o = act_i & at_end_w;
  assign cnt_o    = cnt_q;

  always_comb begin
    if (!act_i) begin
      cnt_d = '0;
    end else if (at_end_w) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + IVL_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ssm_sweep.sv
// Triangle generator for the signed delay code.
module ssm_sweep
  import ssm_pkg::*;
#(
  parameter int LIM_W = 5,
  localparam int CW   = LIM_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 act_i,
  input  logic                 step_i,
  input  logic [LIM_W-1:0]     lim_i,
  output logic signed [CW-1:0] code_o,
  output logic                 turn_o
);

  logic signed [CW-1:0] code_q;
  logic signed [CW-1:0] code_d;
  dir_e                 dir_q;
  dir_e                 dir_d;
  int                   cur_w;
  int                   nxt_w;
  int                   lim_w;

  assign cur_w  = int'(code_q);
  assign lim_w  = int'(lim_i);
  assign nxt_w  = step_code(cur_w, dir_q);
  assign code_o = code_q;

  always_comb begin
    code_d = code_q;
    dir_d  = dir_q;
    turn_o = 1'b0;
    if (!act_i) begin
      code_d = '0;
      dir_d  = DIR_UP;
    end else if (step_i) begin
      if (lim_w == 0) begin
        code_d = '0;
        dir_d  = DIR_UP;
      end else begin
        code_d = CW'(nxt_w);
        if (hits_bound(nxt_w, lim_w, dir_q)) begin
          dir_d  = flip_dir(dir_q);
          turn_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      code_q <= '0;
      dir_q  <= DIR_UP;
    end else begin
      code_q <= code_d;
      dir_q  <= dir_d;
    end
  end

endmodule

// File: rtl/ssm_ctrl.sv
// Top of the spread-spectrum delay-code sweeper.
module ssm_ctrl #(
  parameter int LIM_W   = 5,
  parameter int IVL_W   = 8,
  parameter int SEL_W   = 2,
  parameter int PLL_SEL = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  enable_i,
  input  logic [SEL_W-1:0]      clk_sel_i,
  input  logic [LIM_W-1:0]      limit_i,
  input  logic [IVL_W-1:0]      interval_i,
  output logic signed [LIM_W:0] code_o,
  output logic                  bypass_o
);

  localparam logic [SEL_W-1:0] SEL_PLL = SEL_W'(PLL_SEL);

  // Named internal events, also observed by the bound checker.
  logic             pll_pick_w;
  logic             act_w;
  logic             step_w;
  logic             turn_w;
  logic [LIM_W-1:0] lim_q;
  logic [IVL_W-1:0] ivl_q;
  logic [IVL_W-1:0] cnt_q;

  assign pll_pick_w = (clk_sel_i == SEL_PLL);
  assign act_w      = enable_i & pll_pick_w;

  ssm_cfg_hold #(
    .LIM_W (LIM_W),
    .IVL_W (IVL_W)
  ) cfg_i (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .enable_i   (enable_i),
    .limit_i    (limit_i),
    .interval_i (interval_i),
    .lim_q_o    (lim_q),
    .ivl_q_o    (ivl_q)
  );

  ssm_ivl_timer #(
    .IVL_W (IVL_W)
  ) tmr_i (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .act_i    (act_w),
    .ivl_i    (ivl_q),
    .expire_o (step_w),
    .cnt_o    (cnt_q)
  );

  ssm_sweep #(
    .LIM_W (LIM_W)
  ) swp_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .act_i   (act_w),
    .step_i  (step_w),
    .lim_i   (lim_q),
    .code_o  (code_o),
    .turn_o  (turn_w)
  );

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      bypass_o <= 1'b1;
    end else begin
      bypass_o <= ~act_w;
    end
  end

endmodule

// File: rtl/ssm_ctrl_chk.sv
// Cycle-level properties of the sweeper, bound into every ssm_ctrl.
module ssm_ctrl_chk #(
  parameter int LIM_W = 5,
  parameter int IVL_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_n_i,
  input logic                  enable_i,
  input logic                  act_i,
  input logic                  step_i,
  input logic [LIM_W-1:0]      lim_i,
  input logic [IVL_W-1:0]      ivl_i,
  input logic [IVL_W-1:0]      cnt_i,
  input logic signed [LIM_W:0] code_i,
  input logic                  bypass_i
);

  localparam int DW = LIM_W + 2;

  logic signed [LIM_W:0] lim_s;
  logic signed [LIM_W:0] prev_code;
  logic signed [DW-1:0]  dstep;

  assign lim_s = $signed({1'b0, lim_i});
  assign dstep = $signed({code_i[LIM_W], code_i}) - $signed({prev_code[LIM_W], prev_code});

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) prev_code <= '0;
    else          prev_code <= code_i;
  end

  assert_in_bounds_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (code_i <= lim_s) && (code_i >= -lim_s));

  assert_unit_step_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act_i && step_i && (lim_i != '0)) |=> ((dstep == DW'(1)) || (dstep == {DW{1'b1}})));

  assert_hold_between_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act_i && !step_i) |=> $stable(code_i));

  assert_idle_park_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !act_i |=> ((code_i == '0) && bypass_i));

  assert_active_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    act_i |=> !bypass_i);

  assert_zero_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (act_i && (lim_i == '0)) |=> (code_i == '0));

  assert_cfg_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    enable_i |=> ($stable(lim_i) && $stable(ivl_i)));

  assert_timer_range_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    act_i |-> (cnt_i <= ivl_i));

  assert_timer_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !act_i |=> (cnt_i == '0));

endmodule

bind ssm_ctrl ssm_ctrl_chk #(
  .LIM_W (LIM_W),
  .IVL_W (IVL_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_n_i  (rst_n_i),
  .enable_i (enable_i),
  .act_i    (act_w),
  .step_i   (step_w),
  .lim_i    (lim_q),
  .ivl_i    (ivl_q),
  .cnt_i    (cnt_q),
  .code_i   (code_o),
  .bypass_i (bypass_o)
);

// File: tb/ssm_ctrl_tb_top.sv
`timescale 1ns/1ps
module ssm_ctrl_tb_top;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [1:0]        sel = 2'd2;
  logic [4:0]        lim = 5'd0;
  logic [7:0]        ivl = 8'd0;
  logic signed [5:0] code;
  logic              byp;

  int n_chk = 0;
  int n_err = 0;
  int mx = 0;
  int mn = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  int m_lim = 0, m_ivl = 0, m_cnt = 0, m_code = 0;
  bit m_up = 1'b1, m_byp = 1'b1;

  always #2 clk = ~clk;  // 250 MHz

  ssm_ctrl dut_i (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .enable_i   (en),
    .clk_sel_i  (sel),
    .limit_i    (lim),
    .interval_i (ivl),
    .code_o     (code),
    .bypass_o   (byp)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model advanced on each edge, compared 1 ns later.
  always @(posedge clk) begin
    bit act, tick;
    if (!rst_n) begin
      m_lim = 0; m_ivl = 0; m_cnt = 0; m_code = 0; m_up = 1'b1; m_byp = 1'b1;
    end else begin
      act  = en && (sel == 2'd2);
      tick = act && (m_cnt == m_ivl);
      if (!act) begin
        m_cnt = 0; m_code = 0; m_up = 1'b1;
      end else if (tick) begin
        m_cnt = 0;
        if (m_lim > 0) begin
          m_code = m_code + (m_up ? 1 : -1);
          if (m_code == m_lim) m_up = 1'b0;
          else if (m_code == -m_lim) m_up = 1'b1;
        end
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_byp = !act;
      if (!en) begin
        m_lim = int'(lim);
        m_ivl = int'(ivl);
      end
    end
    #1;
    if (!done) begin
      chk(int'(code) == m_code, "R3/R8 model code", int'(code), m_code);
      chk(byp == m_byp, "R9 model bypass", int'(byp), int'(m_byp));
      if (int'(code) > mx) mx = int'(code);
      if (int'(code) < mn) mn = int'(code);
    end
  end

  task automatic set_in(bit e, int s, int l, int v);
    @(negedge clk);
    en  = e;
    sel = s[1:0];
    lim = l[4:0];
    ivl = v[7:0];
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr_ext();
    mx = 0;
    mn = 0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int seq[5];
    seq = '{1, 0, -1, 0, 1};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(int'(code) == 0, "R1 code in reset", int'(code), 0);
    chk(byp == 1'b1, "R1 bypass in reset", int'(byp), 1);
    rst_n = 1'b1;
    edges(1);
    chk(int'(code) == 0, "R1 code after reset", int'(code), 0);
    chk(byp == 1'b1, "R1 bypass after reset", int'(byp), 1);

    // R5, R3, R9: L=3, N=2
    set_in(0, 2, 3, 2);
    edges(2);
    set_in(1, 2, 3, 2);
    edges(2);
    chk(int'(code) == 0, "R5 no step before N+1 edges", int'(code), 0);
    edges(1);
    chk(int'(code) == 1, "R5 first step at edge N+1", int'(code), 1);
    chk(byp == 1'b0, "R9 bypass low while active", int'(byp), 0);
    edges(3);
    chk(int'(code) == 2, "R3 second step upward", int'(code), 2);
    clr_ext();
    edges(40);
    chk(mx == 3, "R4 reaches +L", mx, 3);
    chk(mn == -3, "R4 reaches -L", mn, -3);

    // R7: new bound and interval ignored while enabled
    set_in(1, 2, 7, 0);
    clr_ext();
    edges(60);
    chk(mx == 3, "R7 bound held high side", mx, 3);
    chk(mn == -3, "R7 bound held low side", mn, -3);

    // R2, R8: non-PLL sources park the code
    set_in(1, 0, 7, 0);
    edges(1);
    chk(int'(code) == 0, "R8 code zero next edge", int'(code), 0);
    chk(byp == 1'b1, "R2 bypass for select 0", int'(byp), 1);
    set_in(1, 1, 7, 0);
    edges(10);
    chk(int'(code) == 0 && byp, "R2 idle for select 1", int'(code), 0);
    set_in(1, 3, 7, 0);
    edges(10);
    chk(int'(code) == 0 && byp, "R2 idle for select 3", int'(code), 0);

    // R8, R7: re-entry restarts upward with the held interval N=2
    set_in(1, 2, 7, 0);
    edges(2);
    chk(int'(code) == 0, "R8 restart no early step", int'(code), 0);
    edges(1);
    chk(int'(code) == 1, "R8 restart steps up", int'(code), 1);

    // R9: disable raises bypass
    set_in(0, 2, 0, 4);
    edges(1);
    chk(byp == 1'b1, "R9 bypass after disable", int'(byp), 1);

    // R6: zero bound
    edges(2);
    set_in(1, 2, 0, 4);
    clr_ext();
    edges(40);
    chk(mx == 0 && mn == 0, "R6 zero bound holds code", mx - mn, 0);
    chk(byp == 1'b0, "R6 bypass low with zero bound", int'(byp), 0);

    // R3: L=1, N=0 exact sequence
    set_in(0, 2, 1, 0);
    edges(2);
    set_in(1, 2, 1, 0);
    for (int k = 0; k < 5; k++) begin
      edges(1);
      chk(int'(code) == seq[k], "R3 unit triangle", int'(code), seq[k]);
    end

    // R4: full range L=31, N=0
    set_in(0, 2, 31, 0);
    edges(2);
    set_in(1, 2, 31, 0);
    clr_ext();
    edges(130);
    chk(mx == 31, "R4 full range top", mx, 31);
    chk(mn == -31, "R4 full range bottom", mn, -31);

    // R2: disabled with PLL selected is idle
    set_in(0, 2, 31, 0);
    edges(1);
    chk(int'(code) == 0 && byp, "R2 disabled is idle", int'(code), 0);
    edges(3);
    summary();
  end

endmodule